// File: doc/BRIEF.md
# Legacy Bus Interrupt Combiner

This block gathers the edge-triggered interrupt request lines of a legacy expansion bus into one latched pending word and raises a single interrupt towards a host processor. The bus offers sixteen request numbers, but only eight of them are wired: numbers 3 to 7 and 10 to 12. These eight are packed into a dense 8-bit pending field. Each request line is first passed through a synchronizer and then an edge detector. A rising edge latches the matching pending flag.

The host reads the pending word over a small synchronous register port. It acknowledges sources by writing ones to the flags it has serviced, normally the lowest set flag first, and it keeps doing so until the word reads zero. The combined interrupt output is meant for a host input that triggers on a rising edge. After every acknowledge the output is held low for a programmable gap. If any flag is still set after the gap, the output rises again, so the host never misses a source that is still pending. A read-only identification register reports a major version and an issue number.

Top module: `xbus_irq_combiner`

## Requirements
- R1: Request line `leg_req[n]` maps to a pending flag as follows: lines 3, 4, 5, 6 and 7 map to flags 0 to 4, and lines 10, 11 and 12 map to flags 5, 6 and 7.
- R2: Lines 0, 1, 2, 8, 9, 13, 14 and 15 have no pending flag. Edges on them never change the pending word or `irq_out`.
- R3: A line that rises and stays high for at least two clocks sets its flag exactly once. A line held high does not set the flag again after it is cleared. A falling edge has no effect.
- R4: A read (`bus_sel`=1, `bus_wr`=0) at address 0 returns the pending flags in bits 7:0 with bits 15:8 zero. `bus_rdata` is registered and is valid in the cycle after the request.
- R5: A write at address 0 clears each flag whose bit is one in `bus_wdata[7:0]`. Flags written as zero are kept, and `bus_wdata[15:8]` is ignored.
- R6: If a rising edge for a flag arrives in the same cycle as a write that clears that flag, the flag stays set.
- R7: Outside an acknowledge gap, `irq_out` is high exactly when the pending word was non-zero at the previous clock edge.
- R8: A write at address 0 with a non-zero low byte drives `irq_out` low for `GAP_CYCLES` cycles (default 1), starting at the clock edge of the write. After that, `irq_out` follows R7, so it rises again if any flag remains set.
- R9: A read at address 1 returns `{8'h00, VER_MAJOR[3:0], VER_ISSUE[3:0]}`, which is 16'h0021 by default. Writes to address 1 have no effect. Addresses 2 and 3 read as zero.
- R10: Reset clears all flags and drives `irq_out` and `bus_rdata` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| leg_req | input | 16 | Legacy request lines, indexed by request number, asynchronous |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Combined interrupt to the host, rising-edge meaning |

## Verification
The bench drives each of the sixteen request numbers in turn. A mapping mistake would set the wrong flag, or set a flag for an unwired number. It holds lines high across an acknowledge and then lowers them, so a level-sensitive or both-edge detector would leave a flag set again. It times a rising edge to land exactly on the clearing write, which catches a design where clear beats set. It services three simultaneous sources lowest-first and watches `irq_out` after every write. A design without the low gap would keep the line high and never produce a second rising edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

   // register addresses
   localparam int unsigned REG_PEND = 0;
   localparam int unsigned REG_IDENT = 1;

   // number of set bits in a wiring mask
   function automatic int unsigned mask_pop(logic [31:0] mask);
      int unsigned cnt;
      cnt = 0;
      for (int i = 0; i < 32; i++) begin
         if (mask[i]) cnt++;
      end
      return cnt;
   endfunction

   // position of the k-th set bit (ascending) in a wiring mask
   function automatic int unsigned nth_set(logic [31:0] mask, int unsigned k);
      int unsigned seen;
      int unsigned pos;
      seen = 0;
      pos = 0;
      for (int i = 0; i < 32; i++) begin
         if (mask[i]) begin
            if (seen == k) pos = i;
            seen++;
         end
      end
      return pos;
   endfunction

endpackage

// File: rtl/xirq_edge_sync.sv
module xirq_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic rise_out
);
   if (STAGES < 2) begin : g_bad
      $error("xirq_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_out = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/xirq_pending.sv
module xirq_pending #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_vec,
   input  logic [NUM_SRC-1:0] clr_vec,
   output logic [NUM_SRC-1:0] pend_q
);
   // set dominates clear for every flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_vec) | set_vec;
   end
endmodule

// File: rtl/xirq_host_if.sv
module xirq_host_if
   import xirq_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned NUM_SRC   = 8,
   parameter logic [7:0]  IDENT_VAL = 8'h21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] pend_in,
   output logic [NUM_SRC-1:0] clr_vec,
   output logic               ack_evt
);
   if (DATA_W < 8 || NUM_SRC >= DATA_W || ADDR_W < 1) begin : g_bad
      $error("xirq_host_if: bad width parameters");
   end

   logic              hit_pend;
   logic              hit_ident;
   logic [DATA_W-1:0] rd_word;
   logic              unused_hi;

   assign hit_pend  = (bus_addr == ADDR_W'(REG_PEND));
   assign hit_ident = (bus_addr == ADDR_W'(REG_IDENT));
   assign clr_vec   = (bus_sel && bus_wr && hit_pend) ? bus_wdata[NUM_SRC-1:0] : '0;
   assign ack_evt   = |clr_vec;
   assign unused_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

   always_comb begin
      rd_word = '0;
      if (hit_pend)       rd_word[NUM_SRC-1:0] = pend_in;
      else if (hit_ident) rd_word[7:0] = IDENT_VAL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  bus_rdata <= '0;
      else if (bus_sel && !bus_wr) bus_rdata <= rd_word;
   end
endmodule

// File: rtl/xirq_irq_gen.sv
module xirq_irq_gen #(
   parameter int unsigned GAP_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_evt,
   input  logic any_pend,
   output logic irq_out
);
   if (GAP_CYCLES < 1) begin : g_bad
      $error("xirq_irq_gen: GAP_CYCLES must be at least 1");
   end

   localparam int unsigned CW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

   logic [CW-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         irq_out <= 1'b0;
      end else if (ack_evt) begin
         hold_q  <= CW'(GAP_CYCLES - 1);
         irq_out <= 1'b0;
      end else if (hold_q != '0) begin
         hold_q  <= hold_q - 1'b1;
         irq_out <= 1'b0;
      end else begin
         irq_out <= any_pend;
      end
   end
endmodule

// File: rtl/xbus_irq_combiner.sv
module xbus_irq_combiner
   import xirq_pkg::*;
#(
   parameter int unsigned LEG_W       = 16,
   parameter logic [LEG_W-1:0] LEG_MASK = 16'h1CF8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned GAP_CYCLES  = 1,
   parameter logic [3:0]  VER_MAJOR   = 4'h2,
   parameter logic [3:0]  VER_ISSUE   = 4'h1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEG_W-1:0]  leg_req,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);
   localparam int unsigned NUM_SRC   = mask_pop(32'(LEG_MASK));
   localparam logic [7:0]  IDENT_VAL = {VER_MAJOR, VER_ISSUE};

   if (LEG_W > 32 || NUM_SRC < 1 || NUM_SRC >= DATA_W) begin : g_bad
      $error("xbus_irq_combiner: bad wiring mask or widths");
   end

   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] clr_vec;
   logic [NUM_SRC-1:0] pend_q;
   logic               ack_evt;
   logic               unused_lines;

   // lines with no flag are dropped here
   assign unused_lines = ^(leg_req & ~LEG_MASK);

   // dense packing: k-th wired line (ascending) feeds flag k
   for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      localparam int unsigned LINE = nth_set(32'(LEG_MASK), k);
      xirq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk      (clk),
         .rst_n    (rst_n),
         .line_in  (leg_req[LINE]),
         .rise_out (set_vec[k])
      );
   end

   xirq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .pend_q  (pend_q)
   );

   xirq_host_if #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .NUM_SRC   (NUM_SRC),
      .IDENT_VAL (IDENT_VAL)
   ) u_host (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pend_in   (pend_q),
      .clr_vec   (clr_vec),
      .ack_evt   (ack_evt)
   );

   xirq_irq_gen #(.GAP_CYCLES(GAP_CYCLES)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ack_evt  (ack_evt),
      .any_pend (|pend_q),
      .irq_out  (irq_out)
   );
endmodule

// File: rtl/xirq_checker.sv
module xirq_checker
   import xirq_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned NUM_SRC   = 8,
   parameter logic [7:0]  IDENT_VAL = 8'h21
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               irq_out,
   input logic [NUM_SRC-1:0] pend_q,
   input logic [NUM_SRC-1:0] set_vec,
   input logic [NUM_SRC-1:0] clr_vec,
   input logic               ack_evt
);
   // R4
   pend_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == ADDR_W'(REG_PEND)) |=>
      (bus_rdata[NUM_SRC-1:0] == $past(pend_q) && bus_rdata[DATA_W-1:NUM_SRC] == '0));

   // R9
   ident_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == ADDR_W'(REG_IDENT)) |=>
      (bus_rdata == DATA_W'(IDENT_VAL)));

   // R5
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_evt |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));

   // R5
   no_stray_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(pend_q) & ~pend_q & ~$past(clr_vec)) == '0));

   // R6
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_vec & clr_vec)) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));

   // R8
   ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_evt |=> !irq_out);

   // R7
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(|pend_q));
endmodule

bind xbus_irq_combiner xirq_checker #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .NUM_SRC   (NUM_SRC),
   .IDENT_VAL (IDENT_VAL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq_out   (irq_out),
   .pend_q    (pend_q),
   .set_vec   (set_vec),
   .clr_vec   (clr_vec),
   .ack_evt   (ack_evt)
);

// File: tb/xbus_irq_combiner_test.sv
`timescale 1ns/1ps
module xbus_irq_combiner_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] leg_req = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   xbus_irq_combiner uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .leg_req   (leg_req),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   // flag index for a request number, -1 when the number is not wired
   function automatic int flag_of(int n);
      if (n >= 3 && n <= 7)   return n - 3;
      if (n >= 10 && n <= 12) return n - 5;
      return -1;
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic rd(logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wr(logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   initial begin : watchdog
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [15:0] d;
      logic [15:0] exp;
      logic [15:0] low;
      int f;
      idle(4);
      // R10 reset state
      chk("R10 irq in reset", {15'd0, irq_out}, 16'h0);
      chk("R10 rdata in reset", bus_rdata, 16'h0);
      rst_n = 1'b1;
      idle(2);
      rd(2'd0, d);
      chk("R10 pending after reset", d, 16'h0);

      // R9 identification register
      rd(2'd1, d);
      chk("R9 ident", d, 16'h0021);
      wr(2'd1, 16'hFFFF);
      rd(2'd1, d);
      chk("R9 ident after write", d, 16'h0021);
      rd(2'd2, d);
      chk("R9 addr 2 zero", d, 16'h0);
      rd(2'd3, d);
      chk("R9 addr 3 zero", d, 16'h0);

      // R1 R2 R3 sweep over every request number
      for (int n = 0; n < 16; n++) begin
         f = flag_of(n);
         exp = (f < 0) ? 16'h0 : (16'h1 << f);
         @(negedge clk);
         leg_req[n] = 1'b1;
         idle(5);
         rd(2'd0, d);
         chk((f < 0) ? "R2 unwired line" : "R1 line to flag", d, exp);
         chk((f < 0) ? "R2 irq stays low" : "R7 irq high", {15'd0, irq_out}, {15'd0, (f >= 0)});
         wr(2'd0, (f < 0) ? 16'h00FF : exp);
         idle(6);
         rd(2'd0, d);
         chk("R3 held level no retrigger", d, 16'h0);
         chk("R7 irq low when empty", {15'd0, irq_out}, 16'h0);
         @(negedge clk);
         leg_req[n] = 1'b0;
         idle(5);
         rd(2'd0, d);
         chk("R3 falling edge ignored", d, 16'h0);
      end

      // R5 R8 three sources, serviced lowest first
      @(negedge clk);
      leg_req[12] = 1'b1; leg_req[4] = 1'b1; leg_req[7] = 1'b1;
      idle(6);
      rd(2'd0, d);
      chk("R1 multi-source", d, 16'h0092);
      wr(2'd0, 16'hFF00);
      idle(1);
      rd(2'd0, d);
      chk("R5 upper byte ignored", d, 16'h0092);
      chk("R7 irq still high", {15'd0, irq_out}, 16'h1);
      exp = 16'h0092;
      for (int it = 0; it < 3; it++) begin
         low = exp & (~exp + 16'h1);
         @(negedge clk);
         bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = low;
         @(negedge clk);
         bus_sel = 1'b0; bus_wr = 1'b0;
         chk("R8 irq low after ack", {15'd0, irq_out}, 16'h0);
         exp = exp & ~low;
         @(negedge clk);
         chk("R8 irq re-rises if pending", {15'd0, irq_out}, {15'd0, (exp != 0)});
         rd(2'd0, d);
         chk("R5 remaining flags", d, exp);
      end
      @(negedge clk);
      leg_req = '0;
      idle(5);

      // R6 edge and clear in the same cycle
      @(negedge clk);
      leg_req[6] = 1'b1;
      idle(5);
      @(negedge clk);
      leg_req[6] = 1'b0;
      idle(5);
      rd(2'd0, d);
      chk("R1 line 6 flag", d, 16'h0008);
      @(negedge clk);
      leg_req[5] = 1'b1;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'h000C;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      rd(2'd0, d);
      chk("R6 set wins over clear", d, 16'h0004);
      wr(2'd0, 16'h0004);
      @(negedge clk);
      leg_req[5] = 1'b0;
      idle(5);
      rd(2'd0, d);
      chk("R5 final clear", d, 16'h0);
      chk("R7 final irq low", {15'd0, irq_out}, 16'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule